// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives the bit-level timing of a CAN node from the system clock. A programmable divider splits the clock into time quanta. Each nominal bit is then walked through three phases: a one-quantum synchronization segment, a first phase segment and a second phase segment. The block emits a one-cycle sample strobe where the first phase ends and a one-cycle bit-end strobe where the second phase ends. Every field is programmed as its length minus one.

The block also watches the already-synchronized receive line for falling (recessive-to-dominant) edges. When the bus is idle, such an edge restarts the bit from the synchronization segment. During traffic, an edge in the first phase stretches that phase, and an edge in the second phase trims that phase. Both adjustments are capped by a programmable jump width, and at most one adjustment is made per bit. A combinational flag reports field combinations that break the timing rules, and those rules depend on whether the divider field is zero.

The fields are captured only while the configuration input is high. During that time all counters are held at the start of a bit, and the counters start running once the configuration input falls.

Top module: `can_bit_timer`

## Requirements
- R1: While running and with no hard synchronization, `tq_tick` pulses for one cycle every `psc_cfg`+1 clock cycles. The first pulse comes `psc_cfg` cycles after the configuration input falls.
- R2: A bit with no edge activity lasts (3 + `ph1_cfg` + `ph2_cfg`) quanta. `bit_end` pulses on the clock cycle of the last quantum tick of each bit.
- R3: `sample_strobe` pulses on the final tick of the first phase segment, which is (2 + `ph1_cfg`) quanta into the bit. `seg_state` reads 0 during synchronization, 1 during the first phase and 2 during the second phase.
- R4: `sample_strobe` and `bit_end` never coincide. Neither strobe nor `tq_tick` is raised while `cfg_mode` is high.
- R5: With a nonzero divider field, `config_error` is 1 exactly when the first phase is under 2 quanta, the first phase is shorter than the jump width, the second phase is under 2 quanta, or the second phase is shorter than the jump width. Each phase length is its field+1 and the jump width is `jump_cfg`+1.
- R6: With the divider field at zero, `config_error` is 1 exactly when the first phase is under 5 quanta, the second phase is under 2 quanta, or the second phase is shorter than the jump width.
- R7: A falling `rx_in` edge while `bus_idle` is high is a hard synchronization. That cycle carries no strobe and no quantum tick, and the next cycle starts a fresh bit with a fresh quantum.
- R8: A falling edge during quantum k (k = 1, 2, ...) of the first phase, with the bus busy, lengthens the first phase, and therefore the bit, by min(k, jump width) quanta.
- R9: A falling edge during quantum q (q = 0, 1, ...) of the second phase, with the bus busy, shortens the second phase by min(remaining quanta after q, jump width). The bit therefore never ends before quantum q completes.
- R10: A falling edge in the synchronization segment has no effect. After one adjustment, further edges in the same bit have no effect.
- R11: Field inputs are captured only while `cfg_mode` is high. Changing them while running leaves the timing unchanged.
- R12: Reset clears the counters and loads the fields divider 0, first phase field 4, second phase field 1 and jump field 0. With these fields `config_error` is 0, the bit is 8 clocks long, and the sample strobe comes at clock 5 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | High: capture fields, hold counters |
| psc_cfg | input | PSC_W | Quantum length minus one, in clocks |
| ph1_cfg | input | TS1_W | First phase length minus one, in quanta |
| ph2_cfg | input | TS2_W | Second phase length minus one, in quanta |
| jump_cfg | input | SJW_W | Jump width minus one, in quanta |
| bus_idle | input | 1 | High when no frame is in progress |
| rx_in | input | 1 | Synchronized receive line, 0 = dominant |
| tq_tick | output | 1 | Last clock of each quantum |
| sample_strobe | output | 1 | Sample point pulse |
| bit_end | output | 1 | Last clock of each bit |
| seg_state | output | 2 | Current segment: 0 sync, 1 first phase, 2 second phase |
| config_error | output | 1 | Programmed fields violate timing rules |

## Verification
Random field sets across the full divider range, with the receive line left quiet, separate errors in quantum length from errors in segment lengths. Edges are placed in chosen quanta: early and late in the first phase, at the start and near the end of the second phase, and in the synchronization segment. Together with a second edge in an already-adjusted bit, these show whether the correction follows the phase error, stops at the jump width and is applied only once. Hard-synchronization edges, one of them on a sample-point cycle, test the restart and the suppression of strobes. Directed field sets sit on each side of every legality limit in both divider regimes.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  // Lengths are in quanta (field + 1). Returns 1 when the set breaks the rules.
  function automatic logic timing_illegal(input int unsigned pre, input int unsigned l1,
                                          input int unsigned l2, input int unsigned jw);
    logic bad;
    bad = (l2 < 2) || (l2 < jw);
    if (pre == 0) bad = bad || (l1 < 5);
    else          bad = bad || (l1 < 2) || (l1 < jw);
    return bad;
  endfunction

  // First phase stretched by the phase error (idx+1), capped at jw.
  function automatic int unsigned grow_len(input int unsigned len, input int unsigned idx,
                                           input int unsigned jw);
    int unsigned step;
    step = idx + 1;
    if (step > jw) step = jw;
    return len + step;
  endfunction

  // Second phase trimmed by the quanta left after idx, capped at jw.
  function automatic int unsigned shrink_len(input int unsigned len, input int unsigned idx,
                                             input int unsigned jw);
    int unsigned rem;
    int unsigned take;
    rem  = len - idx - 1;
    take = (rem < jw) ? rem : jw;
    return len - take;
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q;

  assign tick = !hold && !restart && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (hold || restart) cnt_q <= '0;
    else if (tick)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !tick);
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic rx,
  output logic fall
);
  logic rx_prev_q;

  assign fall = rx_prev_q && !rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_prev_q <= 1'b1;
    else if (hold) rx_prev_q <= 1'b1;
    else           rx_prev_q <= rx;
  end

  // R10
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !hold) |=> !fall);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int JW_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             hsync,
  input  logic             edge_busy,
  input  logic             tick,
  input  logic [LEN_W-1:0] len1,
  input  logic [LEN_W-1:0] len2,
  input  logic [JW_W-1:0]  jw,
  output logic             sample,
  output logic             bit_end,
  output seg_e             seg
);
  seg_e             seg_q;
  logic [LEN_W-1:0] qcnt_q;
  logic [LEN_W-1:0] len_q;
  logic             used_q;
  logic             resync;
  logic [LEN_W-1:0] eff_len;
  logic             last;

  always_comb begin
    resync  = edge_busy && !used_q && (seg_q != SEG_SYNC) && !hold && !hsync;
    eff_len = len_q;
    if (resync && seg_q == SEG_PH1)
      eff_len = LEN_W'(grow_len(32'(len_q), 32'(qcnt_q), 32'(jw)));
    else if (resync && seg_q == SEG_PH2)
      eff_len = LEN_W'(shrink_len(32'(len_q), 32'(qcnt_q), 32'(jw)));
    last = tick && ((qcnt_q + 1'b1) == eff_len);
  end

  assign sample  = last && (seg_q == SEG_PH1) && !hsync;
  assign bit_end = last && (seg_q == SEG_PH2) && !hsync;
  assign seg     = seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || hold || hsync) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      len_q  <= LEN_W'(1);
      used_q <= 1'b0;
    end else begin
      if (resync) begin
        used_q <= 1'b1;
        len_q  <= eff_len;
      end
      if (tick) begin
        if (last) begin
          qcnt_q <= '0;
          case (seg_q)
            SEG_SYNC: begin seg_q <= SEG_PH1; len_q <= len1; end
            SEG_PH1:  begin seg_q <= SEG_PH2; len_q <= len2; end
            default:  begin seg_q <= SEG_SYNC; len_q <= LEN_W'(1); used_q <= 1'b0; end
          endcase
        end else begin
          qcnt_q <= qcnt_q + 1'b1;
        end
      end
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && bit_end));
  // R3
  sample_to_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !hold) |=> (seg_q == SEG_PH2 && qcnt_q == '0));
  // R2
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !hold) |=> (seg_q == SEG_SYNC && !used_q));
  // R7
  hsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (seg_q == SEG_SYNC && qcnt_q == '0 && !used_q));
  // R10
  one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q && !bit_end && !hsync && !hold) |=> used_q);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int PSC_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic [PSC_W-1:0] psc_cfg,
  input  logic [TS1_W-1:0] ph1_cfg,
  input  logic [TS2_W-1:0] ph2_cfg,
  input  logic [SJW_W-1:0] jump_cfg,
  input  logic             bus_idle,
  input  logic             rx_in,
  output logic             tq_tick,
  output logic             sample_strobe,
  output logic             bit_end,
  output logic [1:0]       seg_state,
  output logic             config_error
);
  localparam int LEN_W = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 1;
  localparam int JW_W  = SJW_W + 1;

  logic [PSC_W-1:0] psc_q;
  logic [TS1_W-1:0] ph1_q;
  logic [TS2_W-1:0] ph2_q;
  logic [SJW_W-1:0] jump_q;
  logic [LEN_W-1:0] len1, len2;
  logic [JW_W-1:0]  jw;
  logic             fall, hsync, edge_busy;
  seg_e             seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      ph1_q  <= TS1_W'(4);
      ph2_q  <= TS2_W'(1);
      jump_q <= '0;
    end else if (cfg_mode) begin
      psc_q  <= psc_cfg;
      ph1_q  <= ph1_cfg;
      ph2_q  <= ph2_cfg;
      jump_q <= jump_cfg;
    end
  end

  assign len1 = LEN_W'(ph1_q) + LEN_W'(1);
  assign len2 = LEN_W'(ph2_q) + LEN_W'(1);
  assign jw   = JW_W'(jump_q) + JW_W'(1);
  assign config_error = timing_illegal(32'(psc_q), 32'(len1), 32'(len2), 32'(jw));

  assign hsync     = fall && bus_idle && !cfg_mode;
  assign edge_busy = fall && !bus_idle;
  assign seg_state = 2'(seg);

  can_bt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .hold(cfg_mode), .restart(hsync),
    .div(psc_q), .tick(tq_tick)
  );

  can_bt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .hold(cfg_mode), .rx(rx_in), .fall(fall)
  );

  can_bt_seq #(.LEN_W(LEN_W), .JW_W(JW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(cfg_mode), .hsync(hsync),
    .edge_busy(edge_busy), .tick(tq_tick), .len1(len1), .len2(len2), .jw(jw),
    .sample(sample_strobe), .bit_end(bit_end), .seg(seg)
  );

  // R11
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(psc_q) && $stable(ph1_q) && $stable(ph2_q) && $stable(jump_q)));
  // R5 R6
  ph2_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_q == '0) |-> config_error);
endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, cfg = 1'b1, idle = 1'b0, rx = 1'b1;
  logic [5:0] psc_i = 6'd9;
  logic [3:0] ts1_i = 4'd0;
  logic [2:0] ts2_i = 3'd0;
  logic [1:0] sjw_i = 2'd0;
  logic tq, smp, bend, cerr;
  logic [1:0] seg;

  int checks = 0, fails = 0;
  int cyc, s_at, e_at, bstart, qbase;
  int Q, L1, L2, W;
  bit rs_used, finished = 0;

  always #10 clk = ~clk;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg), .psc_cfg(psc_i), .ph1_cfg(ts1_i),
    .ph2_cfg(ts2_i), .jump_cfg(sjw_i), .bus_idle(idle), .rx_in(rx),
    .tq_tick(tq), .sample_strobe(smp), .bit_end(bend), .seg_state(seg),
    .config_error(cerr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int exp_bad(int p, int a, int b, int j);
    int l1 = a + 1, l2 = b + 1, w = j + 1;
    if (l2 < 2 || l2 < w) return 1;
    if (p == 0) return (l1 < 5) ? 1 : 0;
    return (l1 < 2 || l1 < w) ? 1 : 0;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic void new_bit(int b);
    bstart = b;
    s_at = b + (1 + L1) * Q - 1;
    e_at = b + (1 + L1 + L2) * Q - 1;
    rs_used = 0;
  endfunction

  task automatic step(input string tag);
    int etq, eseg;
    #1;
    etq = (cyc >= qbase && ((cyc - qbase) % Q) == Q - 1) ? 1 : 0;
    chk({"R1 tq_tick ", tag}, tq, etq);
    chk({"R3 sample_strobe ", tag}, smp, (cyc == s_at) ? 1 : 0);
    chk({"R2 bit_end ", tag}, bend, (cyc == e_at) ? 1 : 0);
    if (cyc >= bstart) begin
      eseg = (cyc - bstart < Q) ? 0 : (cyc <= s_at) ? 1 : 2;
      chk({"R3 seg_state ", tag}, seg, eseg);
    end
    if (cyc == e_at) new_bit(cyc + 1);
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_until(input int c, input string tag);
    while (cyc < c) step(tag);
  endtask

  task automatic start_run(input int p, input int a, input int b, input int j, input string tag);
    @(negedge clk);
    cfg = 1; rx = 1; idle = 0;
    psc_i = 6'(p); ts1_i = 4'(a); ts2_i = 3'(b); sjw_i = 2'(j);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk({tag, " config_error"}, cerr, exp_bad(p, a, b, j));
    chk("R4 no strobe in cfg", {29'd0, tq, smp, bend}, 0);
    @(negedge clk);
    Q = p + 1; L1 = a + 1; L2 = b + 1; W = j + 1;
    cfg = 0; cyc = 0; qbase = 0;
    new_bit(0);
  endtask

  // Drive a falling edge in the current cycle and update expectations.
  task automatic pulse(input bit on_idle, input string tag);
    int k, q;
    rx = 0; idle = on_idle;
    if (on_idle) begin
      new_bit(cyc + 1);
      qbase = cyc + 1;
    end else if (!rs_used) begin
      k = (cyc - bstart) / Q;
      if (k >= 1 && k <= L1) begin
        s_at += imin(k, W) * Q;
        e_at += imin(k, W) * Q;
        rs_used = 1;
      end else if (k > L1) begin
        q = k - 1 - L1;
        e_at -= imin(L2 - q - 1, W) * Q;
        rs_used = 1;
      end
    end
    step(tag);
    rx = 1; idle = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cyc = 0;
    // R12: reset state with cfg held high
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset tq_tick", tq, 0);
    chk("R12 reset sample", smp, 0);
    chk("R12 reset bit_end", bend, 0);
    chk("R12 reset seg", seg, 0);
    chk("R12 reset config_error", cerr, 0);
    @(negedge clk);
    rst_n = 1; cfg = 0;
    Q = 1; L1 = 5; L2 = 2; W = 1; cyc = 0; qbase = 0;
    new_bit(0);
    run_until(24, "R12 defaults");

    // R5 / R6 legality limits
    start_run(0, 3, 1, 0, "R6"); run_until(Q * (3 + 3 + 1), "R6");
    start_run(0, 4, 1, 1, "R6"); run_until(10, "R6");
    start_run(0, 4, 1, 2, "R6"); run_until(10, "R6");
    start_run(0, 0, 3, 3, "R6"); run_until(10, "R6");
    start_run(1, 0, 1, 0, "R5"); run_until(10, "R5");
    start_run(1, 1, 1, 0, "R5"); run_until(10, "R5");
    start_run(1, 1, 3, 2, "R5"); run_until(10, "R5");
    start_run(5, 2, 2, 2, "R5"); run_until(40, "R5");
    start_run(5, 7, 0, 0, "R5"); run_until(40, "R5");

    // Random field sets, quiet line; inputs scrambled mid-run (R11)
    for (int n = 0; n < 12; n++) begin
      int p, a, b, j, half;
      p = $urandom_range(0, 63); a = $urandom_range(0, 15);
      b = $urandom_range(0, 7);  j = $urandom_range(0, 3);
      start_run(p, a, b, j, (p == 0) ? "R6 random" : "R5 random");
      half = (3 + a + b) * (p + 1);
      run_until(half, "R2 random");
      psc_i = 6'($urandom); ts1_i = 4'($urandom); ts2_i = 3'($urandom); sjw_i = 2'($urandom);
      run_until(2 * half, "R11 random");
    end

    // Resynchronization with jump width 3
    start_run(2, 6, 3, 2, "R5");
    run_until(10, "R8");  pulse(0, "R8 ph1 k3");
    run_until(38, "R10"); pulse(0, "R10 second edge");
    run_until(bstart, "R10");
    run_until(bstart + 1, "R10"); pulse(0, "R10 sync edge");
    run_until(bstart + Q + 1, "R8"); pulse(0, "R8 ph1 k1");
    run_until(e_at + 1, "R8");
    run_until(bstart + (1 + L1) * Q + 1, "R9"); pulse(0, "R9 ph2 q0");
    run_until(e_at + 1, "R9");
    run_until(bstart + (3 + L1) * Q, "R9"); pulse(0, "R9 ph2 q2");
    run_until(e_at + 1 + 2 * (1 + L1 + L2) * Q, "R9");

    // Jump width 1: caps
    start_run(2, 6, 3, 0, "R5");
    run_until(5 * Q + 1, "R8"); pulse(0, "R8 cap");
    run_until(e_at + 1, "R8");
    run_until(bstart + (1 + L1) * Q, "R9"); pulse(0, "R9 cap");
    run_until(e_at + 1 + (1 + L1 + L2) * Q, "R9");

    // Hard synchronization
    start_run(1, 4, 2, 1, "R5");
    run_until(7, "R7"); pulse(1, "R7 hsync");
    run_until(s_at, "R7"); pulse(1, "R7 hsync on sample");
    run_until(cyc + 2 * (1 + L1 + L2) * Q, "R7");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule